// File: doc/BRIEF.md
# External Asynchronous SRAM Bus Controller

This block turns 32-bit host requests into cycles on an external asynchronous SRAM bus that is 8 or 16 bits wide. Each request carries a word address, four byte enables and, for writes, the word data. The controller issues one narrow bus cycle per halfword (16-bit mode) or per byte (8-bit mode) that holds at least one enabled byte. It drives chip select, address, byte selects, output enable, write enable and a data bus split into out, in and output-enable. It then pulses a ready flag and returns the assembled read word.

All bus timing comes from cycle counts held in configuration inputs: address setup, read cycle, write pulse, write hold, read-after-write turnaround and the follow-on page read time. An optional page mode keeps output enable low across the follow-on beats of a read, so those beats take only the page read time. Bus width and page mode are captured when a request is accepted. The timing counts are read live, and the integrator keeps them static while the bus is busy.

Top module: `sram_bus_ctrl`

## Requirements
- R1: In 16-bit mode the external address is `{word, h}`, where h is the halfword index within the word. Bit 0 therefore carries host byte-address bit 1. Halfword 0 (bytes 0-1) goes out before halfword 1, on data lanes [7:0] = lower byte and [15:8] = upper byte.
- R2: In 8-bit mode each enabled byte b gets its own cycle, in ascending order. The external address is `{word[AW_EXT-3:0], b[1:0]}`, data uses lanes [7:0], and `mem_bs_n` is 2'b10 (lane 0 selected).
- R3: In 16-bit mode `mem_bs_n[k]` is low exactly when byte 2h+k is enabled. A halfword with no enabled byte gets no bus cycle.
- R4: A read beat holds address with output enable high for max(setup,1) cycles. It then holds output enable low for max(rd_cyc,1) cycles, and input data is sampled in the last of those cycles.
- R5: A write beat holds address for max(setup,1) cycles, then holds write enable low for max(wr_pulse,1) cycles, then keeps address and data for wr_hold cycles (0 allowed). `mem_dq_oe` is high for the whole write access.
- R6: A read accepted right after a completed write waits cfg_turn extra cycles with chip select high. No turnaround is added between the beats of one access, or for read-after-read or write-after-write.
- R7: With page mode on, each read beat after the first skips the setup phase. Output enable stays low and the beat lasts max(page_cyc,1) cycles.
- R8: Chip select stays low across all beats of one access and is high for at least one cycle between accesses. Output enable and write enable are never low together, and neither is low while chip select is high.
- R9: `rsp_ready` is high for exactly one cycle: the last cycle of the final strobe (or hold) phase. In that cycle `rsp_rdata` holds the read bytes, with zero in the lanes of disabled bytes.
- R10: During and right after reset, chip select, output enable and write enable are high, `mem_dq_oe` is low and `rsp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all counts are in its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| cfg_page | input | 1 | Page-mode reads enabled |
| cfg_rd_cyc | input | TW | Read strobe length |
| cfg_setup | input | TW | Address setup before strobe |
| cfg_wr_pulse | input | TW | Write strobe length |
| cfg_wr_hold | input | TW | Address/data hold after write strobe |
| cfg_turn | input | TW | Read-after-write turnaround |
| cfg_page_cyc | input | TW | Follow-on page beat length |
| req_valid | input | 1 | Request present; held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | AW_EXT-1 | Host word address |
| req_be | input | 4 | Byte enables (zero is treated as all four) |
| req_wdata | input | 32 | Write word |
| rsp_ready | output | 1 | Access complete pulse |
| rsp_rdata | output | 32 | Read word, valid with rsp_ready |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_addr | output | AW_EXT | External address |
| mem_bs_n | output | 2 | Byte-lane selects, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 16 | Write data toward memory |
| mem_dq_in | input | 16 | Read data from memory |
| mem_dq_oe | output | 1 | Data bus drive enable |

## Verification
Corrupted phase or counter state appears within a cycle as a strobe edge at the wrong cycle. The reference model checks every cycle, so an early or late edge on output enable or write enable is caught on the cycle where it happens. A wrong beat index or lane latch appears on the external address or byte selects as soon as chip select falls for that beat. A lost read capture appears only in `rsp_rdata` at the ready cycle. A stale write history appears as a missing or extra block of high chip-select cycles before the next read.

// File: rtl/sbc_pkg.sv
`timescale 1ns/1ps
// Shared types for the SRAM bus controller.
package sbc_pkg;
    // Bus phase of the controller sequencer.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_TURN,
        PH_SETUP,
        PH_STROBE,
        PH_RECOVER
    } phase_e;

    // Index of a narrow beat inside one host word.
    typedef logic [1:0] beat_t;

    localparam int HOST_BYTES = 4;
endpackage

// File: rtl/sbc_phase_cnt.sv
`timescale 1ns/1ps
// Down-counter that times one bus phase.
// Assumes: load_val is the phase length minus one; expired is high in the
// last cycle of the phase.
module sbc_phase_cnt #(
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    // Load on phase entry, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sbc_beat_plan.sv
`timescale 1ns/1ps
// Picks which narrow beats an access needs and in which order.
// Assumes: be is never zero (the top substitutes all-ones); beats are
// visited in ascending index order.
module sbc_beat_plan
    import sbc_pkg::*;
(
    input  logic       wide,
    input  logic [3:0] be,
    input  beat_t      cur,
    output beat_t      first,
    output beat_t      nxt,
    output logic       has_next
);
    logic [3:0] need;

    // One flag per beat: halfwords in 16-bit mode, bytes in 8-bit mode.
    always_comb begin
        if (wide)
            need = {2'b00, |be[3:2], |be[1:0]};
        else
            need = be;
    end

    // Lowest needed beat, and lowest needed beat above the current one.
    always_comb begin
        first    = '0;
        nxt      = '0;
        has_next = 1'b0;
        for (int i = 3; i >= 0; i--) begin
            if (need[i])
                first = beat_t'(i);
            if (need[i] && (beat_t'(i) > cur)) begin
                nxt      = beat_t'(i);
                has_next = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sbc_lane_map.sv
`timescale 1ns/1ps
// Maps the current beat to external address, byte selects and data lanes,
// and merges captured read bytes into the host word.
// Assumes: cur is a beat the plan marked as needed.
module sbc_lane_map
    import sbc_pkg::*;
#(
    parameter int AW_EXT = 20
) (
    input  logic              wide,
    input  logic [AW_EXT-2:0] word,
    input  logic [3:0]        be,
    input  logic [31:0]       wdata,
    input  beat_t             cur,
    input  logic [15:0]       din,
    input  logic [31:0]       rbuf,
    output logic [AW_EXT-1:0] ext_addr,
    output logic [1:0]        bs_n,
    output logic [15:0]       dout,
    output logic [31:0]       rmerge
);
    // Address remap: halfword count in 16-bit mode, byte count in 8-bit mode.
    always_comb begin
        if (wide)
            ext_addr = {word, cur[0]};
        else
            ext_addr = {word[AW_EXT-3:0], cur};
    end

    // Lane selects and write data for the current beat.
    always_comb begin
        if (wide) begin
            bs_n = cur[0] ? ~be[3:2] : ~be[1:0];
            dout = cur[0] ? wdata[31:16] : wdata[15:0];
        end else begin
            bs_n = 2'b10;
            dout = {8'h00, wdata[8*cur +: 8]};
        end
    end

    // Per host byte: take the bus lane if this beat carries it, else keep.
    for (genvar k = 0; k < HOST_BYTES; k++) begin : g_byte
        localparam logic HALF = ((k / 2) == 1);
        localparam int   SUB  = k % 2;
        logic hit_w;
        logic hit_n;
        assign hit_w = wide && be[k] && (cur[0] == HALF);
        assign hit_n = !wide && be[k] && (cur == beat_t'(k));
        assign rmerge[8*k +: 8] = hit_w ? din[8*SUB +: 8] :
                                  hit_n ? din[7:0] : rbuf[8*k +: 8];
    end
endmodule

// File: rtl/sram_bus_ctrl.sv
`timescale 1ns/1ps
// External asynchronous SRAM bus controller.
// Splits a 32-bit host access into 8- or 16-bit bus beats with
// programmable setup, strobe, hold, turnaround and page timing.
// Assumes: request fields stay stable while req_valid is high until
// rsp_ready; timing inputs are static while the bus is busy.
module sram_bus_ctrl
    import sbc_pkg::*;
#(
    parameter int AW_EXT = 20,
    parameter int TW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wide,
    input  logic              cfg_page,
    input  logic [TW-1:0]     cfg_rd_cyc,
    input  logic [TW-1:0]     cfg_setup,
    input  logic [TW-1:0]     cfg_wr_pulse,
    input  logic [TW-1:0]     cfg_wr_hold,
    input  logic [TW-1:0]     cfg_turn,
    input  logic [TW-1:0]     cfg_page_cyc,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW_EXT-2:0] req_word,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    output logic              rsp_ready,
    output logic [31:0]       rsp_rdata,
    output logic              mem_cs_n,
    output logic [AW_EXT-1:0] mem_addr,
    output logic [1:0]        mem_bs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [15:0]       mem_dq_out,
    input  logic [15:0]       mem_dq_in,
    output logic              mem_dq_oe
);
    localparam int WAW = AW_EXT - 1;

    // Zero counts stretch to one cycle for setup and strobe phases.
    function automatic logic [TW-1:0] at_least_one(input logic [TW-1:0] v);
        return (v == '0) ? TW'(1) : v;
    endfunction

    phase_e          phase_q, phase_d;
    logic            wr_q, wide_q, page_q, last_wr_q;
    logic [3:0]      be_q;
    logic [WAW-1:0]  word_q;
    logic [31:0]     wdata_q, rbuf_q;
    beat_t           cur_q;

    logic            load, expired, accept, step, done, rd_capture;
    logic [TW-1:0]   load_val;
    logic [3:0]      be_in;
    logic            plan_wide;
    logic [3:0]      plan_be;
    beat_t           first, nxt;
    logic            has_next;
    logic            turn_needed;
    logic [31:0]     rmerge;

    assign be_in     = (req_be == 4'h0) ? 4'hF : req_be;
    assign plan_wide = (phase_q == PH_IDLE) ? cfg_wide : wide_q;
    assign plan_be   = (phase_q == PH_IDLE) ? be_in : be_q;
    assign turn_needed = !req_write && last_wr_q && (cfg_turn != '0);

    sbc_beat_plan u_plan (
        .wide     (plan_wide),
        .be       (plan_be),
        .cur      (cur_q),
        .first    (first),
        .nxt      (nxt),
        .has_next (has_next)
    );

    sbc_phase_cnt #(.TW(TW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    sbc_lane_map #(.AW_EXT(AW_EXT)) u_lane (
        .wide     (wide_q),
        .word     (word_q),
        .be       (be_q),
        .wdata    (wdata_q),
        .cur      (cur_q),
        .din      (mem_dq_in),
        .rbuf     (rbuf_q),
        .ext_addr (mem_addr),
        .bs_n     (mem_bs_n),
        .dout     (mem_dq_out),
        .rmerge   (rmerge)
    );

    // Phase sequencing and phase-length selection.
    always_comb begin
        phase_d  = phase_q;
        load     = 1'b0;
        load_val = '0;
        accept   = 1'b0;
        step     = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    load   = 1'b1;
                    if (turn_needed) begin
                        phase_d  = PH_TURN;
                        load_val = cfg_turn - 1'b1;
                    end else begin
                        phase_d  = PH_SETUP;
                        load_val = at_least_one(cfg_setup) - 1'b1;
                    end
                end
            end
            PH_TURN: begin
                if (expired) begin
                    phase_d  = PH_SETUP;
                    load     = 1'b1;
                    load_val = at_least_one(cfg_setup) - 1'b1;
                end
            end
            PH_SETUP: begin
                if (expired) begin
                    phase_d  = PH_STROBE;
                    load     = 1'b1;
                    load_val = (wr_q ? at_least_one(cfg_wr_pulse)
                                     : at_least_one(cfg_rd_cyc)) - 1'b1;
                end
            end
            PH_STROBE: begin
                if (expired) begin
                    if (wr_q && (cfg_wr_hold != '0)) begin
                        phase_d  = PH_RECOVER;
                        load     = 1'b1;
                        load_val = cfg_wr_hold - 1'b1;
                    end else begin
                        step = 1'b1;
                    end
                end
            end
            PH_RECOVER: begin
                if (expired)
                    step = 1'b1;
            end
            default: phase_d = PH_IDLE;
        endcase
        if (step) begin
            if (has_next) begin
                load = 1'b1;
                if (!wr_q && page_q) begin
                    phase_d  = PH_STROBE;
                    load_val = at_least_one(cfg_page_cyc) - 1'b1;
                end else begin
                    phase_d  = PH_SETUP;
                    load_val = at_least_one(cfg_setup) - 1'b1;
                end
            end else begin
                phase_d = PH_IDLE;
            end
        end
    end

    assign done       = step && !has_next;
    assign rd_capture = (phase_q == PH_STROBE) && expired && !wr_q;

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= PH_IDLE;
        else
            phase_q <= phase_d;
    end

    // Request capture at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            wide_q  <= 1'b1;
            page_q  <= 1'b0;
            be_q    <= 4'hF;
            word_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            wr_q    <= req_write;
            wide_q  <= cfg_wide;
            page_q  <= cfg_page;
            be_q    <= be_in;
            word_q  <= req_word;
            wdata_q <= req_wdata;
        end
    end

    // Beat pointer: first beat on accept, next beat on each beat end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_q <= '0;
        else if (accept)
            cur_q <= first;
        else if (step && has_next)
            cur_q <= nxt;
    end

    // Read byte accumulation across beats.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rbuf_q <= '0;
        else if (accept)
            rbuf_q <= '0;
        else if (rd_capture)
            rbuf_q <= rmerge;
    end

    // Direction of the last finished access, for turnaround.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_wr_q <= 1'b0;
        else if (done)
            last_wr_q <= wr_q;
    end

    assign rsp_ready = done;
    assign rsp_rdata = rmerge;
    assign mem_cs_n  = (phase_q == PH_IDLE) || (phase_q == PH_TURN);
    assign mem_oe_n  = !((phase_q == PH_STROBE) && !wr_q);
    assign mem_we_n  = !((phase_q == PH_STROBE) && wr_q);
    assign mem_dq_oe = wr_q && !mem_cs_n;
endmodule

// File: rtl/sbc_checks.sv
`timescale 1ns/1ps
// Protocol checker for the SRAM bus controller, bound to its top.
// Assumes: cfg_wide only changes while chip select is high.
module sbc_checks #(
    parameter int AW_EXT = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wide,
    input logic              rsp_ready,
    input logic              mem_cs_n,
    input logic [AW_EXT-1:0] mem_addr,
    input logic [1:0]        mem_bs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [15:0]       mem_dq_out,
    input logic              mem_dq_oe
);
    // R8: the two strobes never overlap.
    a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    // R8: a strobe only inside a chip-select window.
    a_r8_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> !mem_cs_n);

    // R8: chip select rises after each completed access.
    a_r8_gap_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> mem_cs_n);

    // R9: ready is a single-cycle pulse.
    a_r9_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> !rsp_ready);

    // R5: the data bus is driven while write enable is low.
    a_r5_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

    // R5: address and data hold still during the write pulse.
    a_r5_hold_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

    // R4: the bus is never driven while output enable is low.
    a_r4_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

    // R2: in 8-bit mode only lane 0 is selected.
    a_r2_narrow_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !cfg_wide) |-> (mem_bs_n == 2'b10));
endmodule

bind sram_bus_ctrl sbc_checks #(.AW_EXT(AW_EXT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wide   (cfg_wide),
    .rsp_ready  (rsp_ready),
    .mem_cs_n   (mem_cs_n),
    .mem_addr   (mem_addr),
    .mem_bs_n   (mem_bs_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sim_sram_bus_ctrl.sv
`timescale 1ns/1ps
// Bench: behavioural per-cycle reference model plus a byte-array SRAM.
module sim_sram_bus_ctrl;
    localparam int AW = 20;
    localparam int TW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          cfg_wide = 1'b1, cfg_page = 1'b0;
    logic [TW-1:0] cfg_rd_cyc = '0, cfg_setup = '0, cfg_wr_pulse = '0;
    logic [TW-1:0] cfg_wr_hold = '0, cfg_turn = '0, cfg_page_cyc = '0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-2:0] req_word = '0;
    logic [3:0]    req_be = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_ready;
    logic [31:0]   rsp_rdata;
    logic          mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [AW-1:0] mem_addr;
    logic [1:0]    mem_bs_n;
    logic [15:0]   mem_dq_out, mem_dq_in;

    sram_bus_ctrl #(.AW_EXT(AW), .TW(TW)) u0 (.*);

    // Byte-array SRAM: host byte address maps to the same index in both widths.
    logic [7:0] bmem [256];
    assign mem_dq_in = cfg_wide ? {bmem[{mem_addr[6:0], 1'b1}], bmem[{mem_addr[6:0], 1'b0}]}
                                : {8'h00, bmem[mem_addr[7:0]]};
    always @(negedge clk) begin
        if (rst_n && !mem_we_n) begin
            if (cfg_wide) begin
                if (!mem_bs_n[0]) bmem[{mem_addr[6:0], 1'b0}] <= mem_dq_out[7:0];
                if (!mem_bs_n[1]) bmem[{mem_addr[6:0], 1'b1}] <= mem_dq_out[15:8];
            end else begin
                bmem[mem_addr[7:0]] <= mem_dq_out[7:0];
            end
        end
    end

    typedef struct {
        bit cs_n; bit oe_n; bit we_n; bit rdy; bit doe;
        int addr; int bs; int dout;
    } exp_t;
    exp_t q[$];
    int errs = 0;
    int checks = 0;
    bit last_wr = 1'b0;

    function automatic int tmin(int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic void push(bit cs_n, bit oe_n, bit we_n, bit doe, int a, int bs, int d);
        exp_t e;
        e.cs_n = cs_n; e.oe_n = oe_n; e.we_n = we_n; e.rdy = 1'b0;
        e.doe = doe; e.addr = a; e.bs = bs; e.dout = d;
        q.push_back(e);
    endfunction

    // Reference timeline for one access, from the requirements.
    function automatic void plan(bit wr, int haddr, bit [3:0] be, bit [31:0] wd);
        int nb;
        bit first;
        q.delete();
        if (!wr && last_wr && cfg_turn != 0)
            for (int i = 0; i < int'(cfg_turn); i++) push(1, 1, 1, 0, 0, 0, 0);
        nb = cfg_wide ? 2 : 4;
        first = 1'b1;
        for (int b = 0; b < nb; b++) begin
            bit sel, pg;
            int a, bs, d, n;
            sel = cfg_wide ? (|be[2*b +: 2]) : be[b];
            if (!sel) continue;
            a  = cfg_wide ? ((haddr >> 2) * 2 + b) : ((haddr >> 2) * 4 + b);
            bs = cfg_wide ? int'(~be[2*b +: 2]) & 3 : 2;
            d  = cfg_wide ? int'(wd[16*b +: 16]) : int'(wd[8*b +: 8]);
            pg = !wr && cfg_page && !first;
            if (!pg)
                for (int i = 0; i < tmin(int'(cfg_setup)); i++) push(0, 1, 1, wr, a, bs, d);
            n = pg ? tmin(int'(cfg_page_cyc)) : (wr ? tmin(int'(cfg_wr_pulse)) : tmin(int'(cfg_rd_cyc)));
            for (int i = 0; i < n; i++) push(0, wr, !wr, wr, a, bs, d);
            if (wr)
                for (int i = 0; i < int'(cfg_wr_hold); i++) push(0, 1, 1, 1, a, bs, d);
            first = 1'b0;
        end
        q[q.size()-1].rdy = 1'b1;
    endfunction

    // One access, called and returning at a falling edge with the bus idle.
    task automatic access(bit wr, int haddr, bit [3:0] be, bit [31:0] wd);
        bit [31:0] exp_rd;
        exp_rd = '0;
        for (int j = 0; j < 4; j++)
            if (be[j]) exp_rd[8*j +: 8] = bmem[8'(haddr + j)];
        plan(wr, haddr, be, wd);
        req_valid = 1'b1;
        req_write = wr;
        req_word  = (AW-1)'(haddr >> 2);
        req_be    = be;
        req_wdata = wd;
        foreach (q[i]) begin
            @(negedge clk);
            chk(mem_cs_n == q[i].cs_n, "R8", "cs_n", mem_cs_n, q[i].cs_n);
            chk(mem_oe_n == q[i].oe_n, "R4", "oe_n", mem_oe_n, q[i].oe_n);
            chk(mem_we_n == q[i].we_n, "R5", "we_n", mem_we_n, q[i].we_n);
            chk(rsp_ready == q[i].rdy, "R9", "ready", rsp_ready, q[i].rdy);
            if (!q[i].cs_n) begin
                chk(int'(mem_addr) == q[i].addr, cfg_wide ? "R1" : "R2", "addr", int'(mem_addr), q[i].addr);
                chk(int'(mem_bs_n) == q[i].bs, "R3", "bs_n", int'(mem_bs_n), q[i].bs);
                chk(mem_dq_oe == q[i].doe, "R5", "dq_oe", mem_dq_oe, q[i].doe);
                if (wr) begin
                    if (cfg_wide)
                        chk(int'(mem_dq_out) == q[i].dout, "R1", "dout", int'(mem_dq_out), q[i].dout);
                    else
                        chk(int'(mem_dq_out[7:0]) == q[i].dout, "R2", "dout", int'(mem_dq_out[7:0]), q[i].dout);
                end
            end
            if (q[i].rdy) begin
                if (!wr) chk(rsp_rdata == exp_rd, "R9", "rdata", int'(rsp_rdata), int'(exp_rd));
                req_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk(mem_cs_n == 1'b1, "R8", "gap cs_n", mem_cs_n, 1);
        chk(rsp_ready == 1'b0, "R9", "ready after", rsp_ready, 0);
        last_wr = wr;
    endtask

    task automatic set_cfg(bit w, bit p, int rc, int su, int wp, int wh, int ta, int pc);
        cfg_wide = w; cfg_page = p;
        cfg_rd_cyc = TW'(rc); cfg_setup = TW'(su); cfg_wr_pulse = TW'(wp);
        cfg_wr_hold = TW'(wh); cfg_turn = TW'(ta); cfg_page_cyc = TW'(pc);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL R9 watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) bmem[i] = 8'(i * 7 + 3);
        set_cfg(1, 0, 10, 3, 10, 1, 0, 2);
        repeat (3) @(negedge clk);
        // R10: outputs idle while reset is held
        chk(mem_cs_n && mem_oe_n && mem_we_n, "R10", "strobes in reset", {mem_cs_n, mem_oe_n, mem_we_n}, 7);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_cs_n && mem_oe_n && mem_we_n, "R10", "strobes after reset", {mem_cs_n, mem_oe_n, mem_we_n}, 7);
        chk(!mem_dq_oe && !rsp_ready, "R10", "doe/ready after reset", {mem_dq_oe, rsp_ready}, 0);

        // R1 R4 R5 R9: 16-bit full word write then read
        access(1, 'h10, 4'hF, 32'hA5A5BDBD);
        access(0, 'h10, 4'hF, 0);
        // R6: turnaround after write only
        set_cfg(1, 0, 10, 3, 10, 1, 7, 2);
        access(1, 'h20, 4'hF, 32'h1234_5678);
        access(0, 'h20, 4'hF, 0);
        access(0, 'h24, 4'hF, 0);
        access(1, 'h24, 4'hF, 32'hCAFE_F00D);
        access(1, 'h28, 4'hF, 32'h0BAD_BEEF);
        // R3: partial words on the 16-bit bus
        access(1, 'h30, 4'b1110, 32'h7788_99AA);
        access(0, 'h30, 4'b1110, 0);
        access(0, 'h30, 4'b0100, 0);
        access(1, 'h34, 4'b0001, 32'h0000_0066);
        // R2: 8-bit bus
        set_cfg(0, 0, 4, 2, 3, 2, 3, 2);
        access(1, 'h40, 4'hF, 32'hDEAD_C0DE);
        access(0, 'h40, 4'hF, 0);
        access(1, 'h44, 4'b1010, 32'h1100_2200);
        access(0, 'h44, 4'hF, 0);
        // R7: page-mode reads
        set_cfg(0, 1, 6, 2, 3, 1, 0, 2);
        access(0, 'h40, 4'hF, 0);
        access(0, 'h44, 4'b1110, 0);
        set_cfg(1, 1, 6, 2, 3, 1, 0, 3);
        access(0, 'h10, 4'hF, 0);
        // R4 R5: zero counts stretch to one cycle, hold/turn allow zero
        set_cfg(1, 0, 0, 0, 0, 0, 0, 0);
        access(1, 'h50, 4'hF, 32'h5555_AAAA);
        access(0, 'h50, 4'hF, 0);
        set_cfg(0, 0, 0, 0, 0, 0, 0, 0);
        access(1, 'h54, 4'hF, 32'h0102_0304);
        access(0, 'h54, 4'hF, 0);
        finish_run();
    end
endmodule